// File: doc/BRIEF.md
# Two-Stage Overflow Watchdog Timer

This block is a system watchdog with two clocks. Software reaches it over a small word-addressed register bus clocked by the bus clock. The timing counter runs on a separate oscillator clock. Software programs a 12-bit period value N and enables the counter. It then keeps the system alive by writing a service bit at regular intervals. One overflow period is `(N+1) * 2^PRESC_W` oscillator cycles. With the default `PRESC_W = 20` this gives the 1024 x 1024 prescale.

The first period that ends without a service write raises an interrupt. If the next full period also ends without service, the block raises a reset request. That request is a level, and it stays high until the block itself is reset. Writes to the control, period and count registers reach the oscillator domain through a request/acknowledge handshake. A busy bit shows while such a write is still pending, and a second configuration write made while busy is discarded. The service write takes the short path: the interrupt drops on the next bus clock edge, and the oscillator side restarts after a two-flop synchroniser.

Register words, by byte offset: 0x0 control (bit 0 enable, bit 1 busy, read only). 0x4 period (field N in bits [31:20]). 0x8 elapsed count (number of prescaled units counted in the current period). 0xC interrupt/service (bit 0 flag on read, service on write of 1).

Top module: `twostage_wdt`

## Requirements
- R1: After reset all four register words read 0, and `irq` and `rst_req` are low.
- R2: The period field N is bits [31:20] of the word at offset 0x4. Bits [19:0] of a write are ignored, and a read returns N in bits [31:20] with zeros below.
- R3: Bit 0 of the control word (offset 0x0) enables counting. While it is 0 the elapsed count read at offset 0x8 does not change.
- R4: A write to offset 0x0, 0x4 or 0x8 sets the busy bit (control bit 1) from the next bus cycle. Busy clears once the write has been applied in the oscillator domain, within 6 oscillator plus 9 bus cycles.
- R5: A write to offset 0x0, 0x4 or 0x8 made while busy is 1 is discarded and leaves the stored settings unchanged.
- R6: When `(N+1) * 2^PRESC_W` oscillator cycles pass after service with counting enabled, the interrupt flag (bit 0 at offset 0xC) and the `irq` output go to 1.
- R7: `rst_req` goes to 1 only when a second full period ends with no service write since the first overflow.
- R8: Once high, `rst_req` stays high through service writes until the block reset is asserted.
- R9: Writing 1 to bit 0 at offset 0xC clears `irq` on the next bus clock edge and restarts both the period and the two-stage sequence. Writing 0 there has no effect.
- R10: Any write to offset 0x8 returns the elapsed count to 0.
- R11: The word at offset 0x8 reads the number of prescaled units counted so far in the current period, in the range 0 to N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| prst_n | input | 1 | Active-low reset, synchronous to pclk |
| osc_clk | input | 1 | Oscillator clock for the counter |
| orst_n | input | 1 | Active-low reset, synchronous to osc_clk |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, valid with bus_sel |
| bus_addr | input | 4 | Byte offset of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | First-overflow interrupt, pclk domain |
| rst_req | output | 1 | Sticky reset request, osc_clk domain |

## Verification
The assertions check on every cycle that a configuration write arriving while busy leaves the stored settings alone. They also check that the oscillator-side settings change only when a handshake request is taken, and that the counter stays frozen while disabled. The remaining per-cycle checks are that the reset request never falls and only rises from the second stage, and that a service write drops the interrupt one edge later. Only the bench scenarios can show the time-based behaviour: the period length for random N, the busy latency bound across the two clocks, the exact point where the interrupt and the reset request appear, and that regular service holds both low indefinitely.

// File: rtl/wdt_pkg.sv
// Shared constants and helpers for the two-stage watchdog.
// Assumes 32-bit register words addressed by byte offset.
package wdt_pkg;
    localparam int PER_W     = 12;   // width of period field N
    localparam int FIELD_LSB = 20;   // position of N in the period word

    localparam logic [3:0] OFS_CTRL = 4'h0;
    localparam logic [3:0] OFS_PER  = 4'h4;
    localparam logic [3:0] OFS_CNT  = 4'h8;
    localparam logic [3:0] OFS_SVC  = 4'hC;

    typedef enum logic [1:0] {
        CFG_NONE = 2'd0,
        CFG_CTRL = 2'd1,
        CFG_PER  = 2'd2,
        CFG_CNT  = 2'd3
    } cfg_kind_e;

    // Binary to Gray conversion
    function automatic logic [PER_W-1:0] bin_to_gray(input logic [PER_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    // Gray to binary conversion
    function automatic logic [PER_W-1:0] gray_to_bin(input logic [PER_W-1:0] g);
        logic [PER_W-1:0] b;
        b[PER_W-1] = g[PER_W-1];
        for (int i = PER_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction
endpackage

// File: rtl/wdt_sync.sv
// Multi-stage flop synchroniser for a vector.
// Assumes each bit is a level or a toggle, or the vector is Gray coded,
// so that no more than one bit changes between samples.
module wdt_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    // Shift the input through the synchroniser stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= '{default: '0};
        end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                st[i] <= st[i-1];
            end
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/wdt_cfg_xfer.sv
// Moves configuration writes from the bus clock into the oscillator
// clock with a toggle request/acknowledge handshake.
// Assumes the bus side holds its shadow values stable while busy, so the
// oscillator side may read them directly once the request arrives.
module wdt_cfg_xfer
    import wdt_pkg::*;
#(
    parameter int NW = 12
) (
    input  logic          pclk,
    input  logic          prst_n,
    input  logic          req_valid,
    input  cfg_kind_e     req_kind,
    input  logic          req_en,
    input  logic [NW-1:0] req_n,
    output logic          busy,
    output logic          sh_en,
    output logic [NW-1:0] sh_n,
    input  logic          osc_clk,
    input  logic          orst_n,
    output logic          o_en,
    output logic [NW-1:0] o_n,
    output logic          o_cnt_init
);
    logic      req_tgl;
    logic      ack_tgl;
    logic      req_s;
    logic      ack_s;
    cfg_kind_e sh_kind;

    assign busy = req_tgl ^ ack_s;

    // Bus side: capture a write into the shadow and raise a request
    always_ff @(posedge pclk) begin
        if (!prst_n) begin
            req_tgl <= 1'b0;
            sh_en   <= 1'b0;
            sh_n    <= '0;
            sh_kind <= CFG_NONE;
        end else if (req_valid && !busy) begin
            sh_kind <= req_kind;
            req_tgl <= ~req_tgl;
            case (req_kind)
                CFG_CTRL: sh_en <= req_en;
                CFG_PER:  sh_n  <= req_n;
                default:  ;
            endcase
        end
    end

    wdt_sync #(.W(1), .STAGES(2)) u_req_sync (
        .clk(osc_clk), .rst_n(orst_n), .d(req_tgl), .q(req_s)
    );

    // Oscillator side: apply the shadow once per request and acknowledge
    always_ff @(posedge osc_clk) begin
        if (!orst_n) begin
            ack_tgl    <= 1'b0;
            o_en       <= 1'b0;
            o_n        <= '0;
            o_cnt_init <= 1'b0;
        end else begin
            o_cnt_init <= 1'b0;
            if (req_s != ack_tgl) begin
                ack_tgl <= req_s;
                case (sh_kind)
                    CFG_CTRL: o_en       <= sh_en;
                    CFG_PER:  o_n        <= sh_n;
                    CFG_CNT:  o_cnt_init <= 1'b1;
                    default:  ;
                endcase
            end
        end
    end

    wdt_sync #(.W(1), .STAGES(2)) u_ack_sync (
        .clk(pclk), .rst_n(prst_n), .d(ack_tgl), .q(ack_s)
    );

    // R5: a configuration write during busy leaves the shadow untouched
    p_busy_drop_r5: assert property (@(posedge pclk) disable iff (!prst_n)
        (busy && req_valid) |=> ($stable(sh_n) && $stable(sh_en)));

    // R4: oscillator-side settings move only when a request is taken
    p_cfg_on_req_r4: assert property (@(posedge osc_clk) disable iff (!orst_n)
        (req_s == ack_tgl) |=> ($stable(o_n) && $stable(o_en)));
endmodule

// File: rtl/wdt_tick_core.sv
// Oscillator-domain counter: prescaler, period counter, two-stage overflow
// tracking and the sticky reset request.
// Assumes the service toggle comes from the bus clock and is synchronised here.
module wdt_tick_core
    import wdt_pkg::*;
#(
    parameter int PW = 20,
    parameter int NW = 12
) (
    input  logic          osc_clk,
    input  logic          orst_n,
    input  logic          en,
    input  logic [NW-1:0] n,
    input  logic          cnt_init,
    input  logic          svc_tgl,
    output logic [NW-1:0] cnt_gray,
    output logic          ovf_tgl,
    output logic          rst_req
);
    logic [PW-1:0] presc;
    logic [NW-1:0] cnt;
    logic          stage;
    logic          svc_s;
    logic          svc_seen;
    logic          svc;
    logic          tick;
    logic          wrap;

    wdt_sync #(.W(1), .STAGES(2)) u_svc_sync (
        .clk(osc_clk), .rst_n(orst_n), .d(svc_tgl), .q(svc_s)
    );

    assign svc  = svc_s ^ svc_seen;
    assign tick = en && (&presc);
    assign wrap = tick && (cnt >= n);

    // Count prescaled units and track consecutive unserviced overflows
    always_ff @(posedge osc_clk) begin
        if (!orst_n) begin
            presc    <= '0;
            cnt      <= '0;
            stage    <= 1'b0;
            svc_seen <= 1'b0;
            ovf_tgl  <= 1'b0;
            rst_req  <= 1'b0;
        end else begin
            svc_seen <= svc_s;
            if (svc || cnt_init) begin
                presc <= '0;
                cnt   <= '0;
                if (svc) begin
                    stage <= 1'b0;
                end
            end else if (en) begin
                presc <= presc + 1'b1;
                if (wrap) begin
                    cnt <= '0;
                    if (!stage) begin
                        stage   <= 1'b1;
                        ovf_tgl <= ~ovf_tgl;
                    end else begin
                        rst_req <= 1'b1;
                    end
                end else if (tick) begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // Register the count in Gray code for the crossing back to the bus
    always_ff @(posedge osc_clk) begin
        if (!orst_n) begin
            cnt_gray <= '0;
        end else begin
            cnt_gray <= bin_to_gray(cnt);
        end
    end

    // R8: the reset request never falls while out of reset
    p_req_sticky_r8: assert property (@(posedge osc_clk) disable iff (!orst_n)
        rst_req |=> rst_req);

    // R7: the reset request rises only from the second stage
    p_req_second_r7: assert property (@(posedge osc_clk) disable iff (!orst_n)
        $rose(rst_req) |-> $past(stage));

    // R6: entering the first stage always signals an interrupt event
    p_first_evt_r6: assert property (@(posedge osc_clk) disable iff (!orst_n)
        $rose(stage) |-> (ovf_tgl != $past(ovf_tgl)));

    // R3: with counting off and no restart, the counter holds
    p_hold_off_r3: assert property (@(posedge osc_clk) disable iff (!orst_n)
        (!en && !svc && !cnt_init) |=> ($stable(cnt) && $stable(presc)));
endmodule

// File: rtl/twostage_wdt.sv
// Top of the two-stage watchdog: bus register decode, interrupt flag,
// count readback crossing, and the two clock-domain halves.
// Assumes pclk and osc_clk are unrelated and that both resets are
// asserted together long enough for each clock to see them.
module twostage_wdt
    import wdt_pkg::*;
#(
    parameter int PRESC_W = 20
) (
    input  logic        pclk,
    input  logic        prst_n,
    input  logic        osc_clk,
    input  logic        orst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        rst_req
);
    localparam int NW = PER_W;
    localparam int PAD_W = 32 - NW;

    logic             wr;
    logic             cfg_valid;
    cfg_kind_e        cfg_kind;
    logic             svc_wr;
    logic             svc_tgl;
    logic             busy;
    logic             sh_en;
    logic [NW-1:0]    sh_n;
    logic             o_en;
    logic [NW-1:0]    o_n;
    logic             o_cnt_init;
    logic [NW-1:0]    cnt_gray;
    logic [NW-1:0]    cnt_gray_s;
    logic [NW-1:0]    cnt_bin;
    logic             ovf_tgl;
    logic             ovf_s;
    logic             ovf_seen;
    logic             evt;
    logic             irq_flag;
    logic             unused_wdata;

    assign wr           = bus_sel && bus_wr;
    assign svc_wr       = wr && (bus_addr == OFS_SVC) && bus_wdata[0];
    assign unused_wdata = ^bus_wdata[FIELD_LSB-1:1];

    // Decode which configuration word a write targets
    always_comb begin
        cfg_kind  = CFG_NONE;
        cfg_valid = 1'b0;
        if (wr) begin
            case (bus_addr)
                OFS_CTRL: begin cfg_kind = CFG_CTRL; cfg_valid = 1'b1; end
                OFS_PER:  begin cfg_kind = CFG_PER;  cfg_valid = 1'b1; end
                OFS_CNT:  begin cfg_kind = CFG_CNT;  cfg_valid = 1'b1; end
                default:  ;
            endcase
        end
    end

    wdt_cfg_xfer #(.NW(NW)) u_xfer (
        .pclk(pclk), .prst_n(prst_n),
        .req_valid(cfg_valid), .req_kind(cfg_kind),
        .req_en(bus_wdata[0]), .req_n(bus_wdata[FIELD_LSB +: NW]),
        .busy(busy), .sh_en(sh_en), .sh_n(sh_n),
        .osc_clk(osc_clk), .orst_n(orst_n),
        .o_en(o_en), .o_n(o_n), .o_cnt_init(o_cnt_init)
    );

    // Toggle the service request on each service write
    always_ff @(posedge pclk) begin
        if (!prst_n) begin
            svc_tgl <= 1'b0;
        end else if (svc_wr) begin
            svc_tgl <= ~svc_tgl;
        end
    end

    wdt_tick_core #(.PW(PRESC_W), .NW(NW)) u_core (
        .osc_clk(osc_clk), .orst_n(orst_n),
        .en(o_en), .n(o_n), .cnt_init(o_cnt_init), .svc_tgl(svc_tgl),
        .cnt_gray(cnt_gray), .ovf_tgl(ovf_tgl), .rst_req(rst_req)
    );

    wdt_sync #(.W(1), .STAGES(2)) u_ovf_sync (
        .clk(pclk), .rst_n(prst_n), .d(ovf_tgl), .q(ovf_s)
    );

    wdt_sync #(.W(NW), .STAGES(2)) u_cnt_sync (
        .clk(pclk), .rst_n(prst_n), .d(cnt_gray), .q(cnt_gray_s)
    );

    assign evt     = ovf_s ^ ovf_seen;
    assign cnt_bin = gray_to_bin(cnt_gray_s);

    // Interrupt flag: set by an overflow event, cleared by service
    always_ff @(posedge pclk) begin
        if (!prst_n) begin
            ovf_seen <= 1'b0;
            irq_flag <= 1'b0;
        end else begin
            ovf_seen <= ovf_s;
            if (evt) begin
                irq_flag <= 1'b1;
            end else if (svc_wr) begin
                irq_flag <= 1'b0;
            end
        end
    end

    assign irq = irq_flag;

    // Read multiplexer for the four register words
    always_comb begin
        case (bus_addr)
            OFS_CTRL: bus_rdata = {30'd0, busy, sh_en};
            OFS_PER:  bus_rdata = {sh_n, {FIELD_LSB{1'b0}}};
            OFS_CNT:  bus_rdata = {{PAD_W{1'b0}}, cnt_bin};
            OFS_SVC:  bus_rdata = {31'd0, irq_flag};
            default:  bus_rdata = 32'd0;
        endcase
    end

    // R9: a service write with no event in flight drops the interrupt next edge
    p_svc_clears_r9: assert property (@(posedge pclk) disable iff (!prst_n)
        (svc_wr && !evt) |=> !irq);

    // R6: the interrupt rises only on an overflow event
    p_irq_cause_r6: assert property (@(posedge pclk) disable iff (!prst_n)
        $rose(irq) |-> $past(evt));
endmodule

// File: tb/twostage_wdt_bench.sv
// Bench for the two-stage watchdog: fixed-seed random periods plus
// directed corner cases, with expected timing computed from N.
module twostage_wdt_bench;
    localparam int PW      = 4;
    localparam int BUSY_MAX = 24; // ceil((6*20 + 9*8) / 8) bus cycles

    logic        pclk = 1'b0;
    logic        oclk = 1'b0;
    logic        prst_n = 1'b0;
    logic        orst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        rst_req;

    int n_cmp = 0;
    int n_bad = 0;

    always #4  pclk = ~pclk;   // 125 MHz bus clock
    always #10 oclk = ~oclk;   // 50 MHz oscillator

    twostage_wdt #(.PRESC_W(PW)) u_twostage_wdt (
        .pclk(pclk), .prst_n(prst_n), .osc_clk(oclk), .orst_n(orst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .rst_req(rst_req)
    );

    function automatic int period_osc(input int n);
        return (n + 1) << PW;
    endfunction

    function automatic logic [31:0] per_word(input logic [31:0] v);
        return v & 32'hFFF0_0000;
    endfunction

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
        n_cmp++;
        if (act < lo || act > hi) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge pclk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge pclk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wait_idle(output int cyc);
        logic [31:0] v;
        cyc = 0;
        for (int k = 0; k < 64; k++) begin
            bus_read(4'h0, v);
            if (!v[1]) break;
            @(negedge pclk);
            cyc++;
        end
    endtask

    task automatic wait_osc(input int k);
        repeat (k) @(posedge oclk);
        @(negedge pclk);
    endtask

    task automatic do_reset();
        prst_n = 1'b0; orst_n = 1'b0;
        bus_sel = 1'b0; bus_wr = 1'b0;
        repeat (10) @(negedge pclk);
        prst_n = 1'b1; orst_n = 1'b1;
        @(negedge pclk);
    endtask

    task automatic setup_run(input int n);
        int c;
        bus_write(4'h0, 32'd0);           wait_idle(c);
        bus_write(4'h4, 32'(n) << 20);    wait_idle(c);
        bus_write(4'h8, 32'd0);           wait_idle(c);
        bus_write(4'hC, 32'd1);
        bus_write(4'h0, 32'd1);           wait_idle(c);
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] a;
        logic [31:0] b;
        int c;
        int c1;
        int t;
        int n;
        void'($urandom(32'h5EED_1234));

        do_reset();
        // R1: reset state
        bus_read(4'h0, v); chk("R1 ctrl", v, 32'd0);
        bus_read(4'h4, v); chk("R1 period", v, 32'd0);
        bus_read(4'h8, v); chk("R1 count", v, 32'd0);
        bus_read(4'hC, v); chk("R1 flag", v, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 rst_req", {31'd0, rst_req}, 32'd0);

        // R2: random period words, low bits ignored
        for (int i = 0; i < 4; i++) begin
            a = $urandom;
            bus_write(4'h4, a);
            wait_idle(c);
            bus_read(4'h4, v);
            chk("R2 period field", v, per_word(a));
        end

        // R4: busy visible right after write, clears within the bound
        bus_write(4'h0, 32'd0);
        bus_read(4'h0, v);
        chk("R4 busy set", {31'd0, v[1]}, 32'd1);
        wait_idle(c);
        chk_rng("R4 busy latency", c, 0, BUSY_MAX);

        // R5: second write during busy is dropped
        for (int i = 0; i < 2; i++) begin
            a = $urandom;
            b = ~a;
            bus_write(4'h4, a);
            bus_write(4'h4, b);
            wait_idle(c);
            bus_read(4'h4, v);
            chk("R5 dropped write", v, per_word(a));
        end

        // R11: count follows prescaled units while enabled
        setup_run(15);
        wait_osc(5 << PW);
        bus_read(4'h8, v);
        chk_rng("R11 count after 5 units", int'(v), 4, 6);

        // R3: disabling freezes the count
        bus_write(4'h0, 32'd0);
        wait_idle(c);
        wait_osc(8);
        bus_read(4'h8, v); c1 = int'(v);
        wait_osc(4 << PW);
        bus_read(4'h8, v);
        chk("R3 count frozen", v, 32'(c1));
        chk("R3 no irq while stopped", {31'd0, irq}, 32'd0);

        // R10: count write returns the count to 0
        bus_write(4'h8, 32'hFFFF_FFFF);
        wait_idle(c);
        wait_osc(8);
        bus_read(4'h8, v);
        chk("R10 count cleared", v, 32'd0);

        // R6..R9: random periods through both stages
        for (int trial = 0; trial < 3; trial++) begin
            n = 2 + int'($urandom % 10);
            t = period_osc(n);
            do_reset();
            setup_run(n);
            wait_osc(t * 7 / 10);
            chk("R6 no irq early", {31'd0, irq}, 32'd0);
            wait_osc(t * 6 / 10);
            chk("R6 irq after period", {31'd0, irq}, 32'd1);
            bus_read(4'hC, v);
            chk("R6 flag bit", v, 32'd1);
            chk("R7 no reset at first overflow", {31'd0, rst_req}, 32'd0);
            bus_write(4'hC, 32'd0);
            chk("R9 zero write ignored", {31'd0, irq}, 32'd1);
            bus_write(4'hC, 32'd1);
            chk("R9 irq cleared at once", {31'd0, irq}, 32'd0);
            wait_osc(t * 13 / 10);
            chk("R9 restart first stage", {31'd0, irq}, 32'd1);
            chk("R9 stage restarted", {31'd0, rst_req}, 32'd0);
            wait_osc(t * 4 / 10);
            chk("R7 no reset before second period", {31'd0, rst_req}, 32'd0);
            wait_osc(t * 6 / 10);
            chk("R7 reset after two periods", {31'd0, rst_req}, 32'd1);
            bus_write(4'hC, 32'd1);
            wait_osc(t / 2);
            chk("R8 reset request held", {31'd0, rst_req}, 32'd1);
            do_reset();
            chk("R8 cleared by block reset", {31'd0, rst_req}, 32'd0);
        end

        // R9/R7: regular service keeps both outputs low
        n = 5;
        t = period_osc(n);
        setup_run(n);
        for (int i = 0; i < 12; i++) begin
            wait_osc(t / 2);
            bus_write(4'hC, 32'd1);
            chk("R9 keep-alive irq", {31'd0, irq}, 32'd0);
            chk("R7 keep-alive rst_req", {31'd0, rst_req}, 32'd0);
        end

        report();
    end
endmodule